// File: doc/BRIEF.md
# Coherence Miss Order Recorder

This block keeps an ordered log of the block addresses of coherence read misses. Each accepted miss address is given the next slot of a circular log in local memory. Addresses are first gathered in a staging register. Once enough of them arrive to fill one cache block, the whole block of addresses goes to memory in a single write. Only addresses are logged; data values never are.

Each accepted address also produces a pointer update carrying this node's identifier and the log slot the address now occupies. A directory can store that pointer and later find the point in the log where a recurring miss sequence starts.

A flush request pushes out a partly filled block with its valid count. Logging then resumes at the next block boundary, so every memory write stays block aligned. When the memory port is slow, the miss input is held off through a ready/valid handshake, so no address is ever dropped.

Top module: `miss_log_recorder`

## Requirements
- R1: After reset, `miss_ready_o` is 1, and `mem_wr_valid_o` and `ptr_valid_o` are 0.
- R2: A miss address is accepted on a clock edge where `miss_valid_i` and `miss_ready_o` are both 1. The cycle after each accepted address, `ptr_valid_o` is 1 for one cycle, with `ptr_node_o` equal to the node ID parameter and `ptr_index_o` equal to the address's log slot. Slots run consecutively in acceptance order.
- R3: With 64-bit addresses and a 64-byte block, a group holds 8 addresses. A group whose 8th address is accepted appears on the memory port on the next cycle, with:
  - `mem_wr_count_o` = 8;
  - `mem_wr_idx_o` = slot / 8;
  - the address of group position k placed at bits [64k+63:64k], in arrival order.
- R4: While `mem_wr_valid_o` is 1 and `mem_wr_ready_i` is 0, the write stays valid and its index, count and data do not change.
- R5: Suppose 7 addresses are staged and a write is pending that memory is not taking in this cycle. Then `miss_ready_o` is 0, and every offered address is eventually logged once, in order.
- R6: The slot after the last log entry (depth − 1) is 0, and the block index wraps in the same way. Older entries are overwritten.
- R7: A flush while n (1 to 7) addresses are staged writes them as one group with count n and zeros in the unused positions. The write happens as soon as the memory port is free. The next accepted address takes the first slot of the following block.
- R8: A flush while no address is staged produces no memory write and does not move the slot counter.
- R9: While `flush_i` is 1, or a flush is waiting for the memory port, `miss_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | Miss address offered |
| miss_ready_o | output | 1 | Miss address can be accepted |
| miss_addr_i | input | ADDR_W | Block address of the coherence miss |
| flush_i | input | 1 | Write out the partly filled group |
| mem_wr_valid_o | output | 1 | Block write request |
| mem_wr_ready_i | input | 1 | Memory takes the block write |
| mem_wr_idx_o | output | BLK_W | Log block index of the write |
| mem_wr_count_o | output | CNT_W | Number of valid addresses in the write |
| mem_wr_data_o | output | GROUP*ADDR_W | Packed addresses, position 0 in the low bits |
| ptr_valid_o | output | 1 | Pointer update valid |
| ptr_node_o | output | NODE_W | Recording node identifier |
| ptr_index_o | output | IDX_W | Log slot of the address just recorded |

## Verification
The first pattern is an unbroken stream of misses with memory always ready. It shows that slots are consecutive and that full groups are packed in arrival order. Holding memory ready low while misses keep arriving tells a correct stall at the eighth staged address apart from an overwrite or a lost address. Sparse, irregular traffic with a toggling memory ready separates a write that is merely held from one that is repeated or dropped. Flushes with partial, empty and backpressured staging, together with runs long enough to pass the log end several times, separate block-aligned restarts and modular wrap from a counter that carries on past the boundary.

// File: rtl/mlr_pkg.sv
package mlr_pkg;
  // a flush may have to wait for the write port
  typedef enum logic {FL_IDLE = 1'b0, FL_WAIT = 1'b1} flush_st_e;
endpackage

// File: rtl/mlr_stage.sv
module mlr_stage
  import mlr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int GROUP  = 8,
  parameter int DEPTH  = 64,
  localparam int GW    = $clog2(GROUP),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BLK_W = IDX_W - GW,
  localparam int CNT_W = GW + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    miss_valid_i,
  input  logic [ADDR_W-1:0]       miss_addr_i,
  input  logic                    flush_i,
  input  logic                    out_free_i,
  output logic                    miss_ready_o,
  output logic                    accept_o,
  output logic [IDX_W-1:0]        acc_idx_o,
  output logic                    grp_go_o,
  output logic [BLK_W-1:0]        grp_blk_o,
  output logic [CNT_W-1:0]        grp_cnt_o,
  output logic [GROUP*ADDR_W-1:0] grp_data_o
);
  logic [IDX_W-1:0]  ptr_q;
  logic [ADDR_W-1:0] slots_q [GROUP];
  flush_st_e         fl_q;

  logic [GW-1:0]    slot;
  logic [BLK_W-1:0] blk;
  logic flush_req, last, flush_go;

  assign slot      = ptr_q[GW-1:0];
  assign blk       = ptr_q[IDX_W-1:GW];
  assign flush_req = flush_i || (fl_q == FL_WAIT);
  assign last      = (slot == GW'(GROUP-1));

  assign miss_ready_o = !flush_req && (!last || out_free_i);
  assign accept_o     = miss_valid_i && miss_ready_o;
  assign acc_idx_o    = ptr_q;
  assign flush_go     = flush_req && (slot != '0) && out_free_i;
  assign grp_go_o     = (accept_o && last) || flush_go;
  assign grp_blk_o    = blk;
  assign grp_cnt_o    = flush_go ? CNT_W'(slot) : CNT_W'(GROUP);

  for (genvar k = 0; k < GROUP; k++) begin : g_pack
    assign grp_data_o[k*ADDR_W +: ADDR_W] =
      (accept_o && slot == GW'(k)) ? miss_addr_i :
      (GW'(k) < slot)              ? slots_q[k]  : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      fl_q  <= FL_IDLE;
    end else begin
      if (accept_o)      ptr_q <= ptr_q + 1'b1;
      else if (flush_go) ptr_q <= {blk + 1'b1, {GW{1'b0}}};
      fl_q <= (flush_req && slot != '0 && !out_free_i) ? FL_WAIT : FL_IDLE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept_o) slots_q[slot] <= miss_addr_i;
  end

  // R5: a completed group never finds the write register occupied
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && last) |-> out_free_i);

  // R8: an empty flush leaves the slot counter where it was
  p_empty_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && slot == '0 && !miss_valid_i) |=> $stable(ptr_q));
endmodule

// File: rtl/mlr_wr_port.sv
module mlr_wr_port #(
  parameter int ADDR_W = 64,
  parameter int GROUP  = 8,
  parameter int BLK_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    go_i,
  input  logic [BLK_W-1:0]        blk_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [GROUP*ADDR_W-1:0] data_i,
  output logic                    out_free_o,
  output logic                    mem_wr_valid_o,
  input  logic                    mem_wr_ready_i,
  output logic [BLK_W-1:0]        mem_wr_idx_o,
  output logic [CNT_W-1:0]        mem_wr_count_o,
  output logic [GROUP*ADDR_W-1:0] mem_wr_data_o
);
  logic v_q;

  assign out_free_o     = !v_q || mem_wr_ready_i;
  assign mem_wr_valid_o = v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q            <= 1'b0;
      mem_wr_idx_o   <= '0;
      mem_wr_count_o <= '0;
      mem_wr_data_o  <= '0;
    end else if (go_i) begin
      v_q            <= 1'b1;
      mem_wr_idx_o   <= blk_i;
      mem_wr_count_o <= cnt_i;
      mem_wr_data_o  <= data_i;
    end else if (mem_wr_ready_i) begin
      v_q <= 1'b0;
    end
  end

  // R4
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_data_o) && $stable(mem_wr_idx_o)
       && $stable(mem_wr_count_o)));

  // R3/R7: a write carries between one and GROUP addresses
  p_count_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> (mem_wr_count_o != '0 && mem_wr_count_o <= CNT_W'(GROUP)));
endmodule

// File: rtl/mlr_ptr_msg.sv
module mlr_ptr_msg #(
  parameter int IDX_W  = 6,
  parameter int NODE_W = 6,
  parameter logic [NODE_W-1:0] NODE_ID = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              ptr_valid_o,
  output logic [NODE_W-1:0] ptr_node_o,
  output logic [IDX_W-1:0]  ptr_index_o
);
  assign ptr_node_o = NODE_ID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_valid_o <= 1'b0;
      ptr_index_o <= '0;
    end else begin
      ptr_valid_o <= accept_i;
      if (accept_i) ptr_index_o <= idx_i;
    end
  end
endmodule

// File: rtl/miss_log_recorder.sv
module miss_log_recorder #(
  parameter int ADDR_W    = 64,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 64,
  parameter int NODE_W    = 6,
  parameter logic [NODE_W-1:0] NODE_ID = 6'd5,
  localparam int GROUP = BLK_BYTES * 8 / ADDR_W,
  localparam int GW    = $clog2(GROUP),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BLK_W = IDX_W - GW,
  localparam int CNT_W = GW + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    miss_valid_i,
  output logic                    miss_ready_o,
  input  logic [ADDR_W-1:0]       miss_addr_i,
  input  logic                    flush_i,
  output logic                    mem_wr_valid_o,
  input  logic                    mem_wr_ready_i,
  output logic [BLK_W-1:0]        mem_wr_idx_o,
  output logic [CNT_W-1:0]        mem_wr_count_o,
  output logic [GROUP*ADDR_W-1:0] mem_wr_data_o,
  output logic                    ptr_valid_o,
  output logic [NODE_W-1:0]       ptr_node_o,
  output logic [IDX_W-1:0]        ptr_index_o
);
  logic                    out_free, accept, grp_go;
  logic [IDX_W-1:0]        acc_idx;
  logic [BLK_W-1:0]        grp_blk;
  logic [CNT_W-1:0]        grp_cnt;
  logic [GROUP*ADDR_W-1:0] grp_data;

  mlr_stage #(.ADDR_W(ADDR_W), .GROUP(GROUP), .DEPTH(DEPTH)) u_stage (
    .clk_i, .rst_ni, .miss_valid_i, .miss_addr_i, .flush_i,
    .out_free_i(out_free), .miss_ready_o, .accept_o(accept),
    .acc_idx_o(acc_idx), .grp_go_o(grp_go), .grp_blk_o(grp_blk),
    .grp_cnt_o(grp_cnt), .grp_data_o(grp_data)
  );

  mlr_wr_port #(.ADDR_W(ADDR_W), .GROUP(GROUP), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_wr (
    .clk_i, .rst_ni, .go_i(grp_go), .blk_i(grp_blk), .cnt_i(grp_cnt),
    .data_i(grp_data), .out_free_o(out_free), .mem_wr_valid_o,
    .mem_wr_ready_i, .mem_wr_idx_o, .mem_wr_count_o, .mem_wr_data_o
  );

  mlr_ptr_msg #(.IDX_W(IDX_W), .NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_ptr (
    .clk_i, .rst_ni, .accept_i(accept), .idx_i(acc_idx),
    .ptr_valid_o, .ptr_node_o, .ptr_index_o
  );

  // R3: the update for a group's last slot coincides with that group's write
  p_block_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_valid_o && ptr_index_o[GW-1:0] == GW'(GROUP-1)) |->
      (mem_wr_valid_o && mem_wr_idx_o == ptr_index_o[IDX_W-1:GW]));

  // R2/R6: back-to-back updates name consecutive slots, modulo depth
  p_ptr_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_valid_o && $past(ptr_valid_o)) |->
      (ptr_index_o == IDX_W'($past(ptr_index_o) + 1'b1)));

  // R9
  p_flush_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !miss_ready_o);
endmodule

// File: tb/miss_log_recorder_tb.sv
module miss_log_recorder_tb_top;
  localparam int AW = 64, GROUP = 8, DEPTH = 64, NODE_W = 6;
  localparam int IDX_W = 6, BLK_W = 3, CNT_W = 4;
  localparam logic [NODE_W-1:0] NODE = 6'd5;

  logic clk = 0, rst_n = 0;
  logic mv = 0, fl = 0, mr = 0;
  logic [AW-1:0] ma = '0;
  logic mrdy, wv, pv;
  logic [BLK_W-1:0] widx;
  logic [CNT_W-1:0] wcnt;
  logic [GROUP*AW-1:0] wdata;
  logic [NODE_W-1:0] pnode;
  logic [IDX_W-1:0] pidx;

  always #10 clk = ~clk;

  miss_log_recorder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .miss_valid_i(mv), .miss_ready_o(mrdy),
    .miss_addr_i(ma), .flush_i(fl), .mem_wr_valid_o(wv), .mem_wr_ready_i(mr),
    .mem_wr_idx_o(widx), .mem_wr_count_o(wcnt), .mem_wr_data_o(wdata),
    .ptr_valid_o(pv), .ptr_node_o(pnode), .ptr_index_o(pidx)
  );

  typedef struct {int blk; int cnt; logic [GROUP*AW-1:0] d;} wr_t;
  wr_t q[$];
  logic [AW-1:0] st [GROUP];
  int ptr = 0, errors = 0, checks = 0, naddr = 0, wraps = 0;
  bit pend = 0, exp_pv = 0, done = 0;
  int exp_pi = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [GROUP*AW-1:0] pack(int n);
    logic [GROUP*AW-1:0] d = '0;
    for (int k = 0; k < n; k++) d[k*AW +: AW] = st[k];
    return d;
  endfunction

  // one cycle: check outputs, drive inputs, advance the model
  task automatic step(bit v, bit f, bit r);
    bit exp_rdy, busy, ofree, acc;
    int cnt;
    @(negedge clk);
    chk(pv == exp_pv, "R2", "ptr_valid", pv, exp_pv);
    if (pv && exp_pv) begin
      chk(pidx == exp_pi, "R2/R6", "ptr_index", pidx, exp_pi);
      chk(pnode == NODE, "R2", "ptr_node", pnode, NODE);
    end
    chk(wv == (q.size() > 0), "R3/R4/R8", "wr_valid", wv, q.size() > 0);
    if (wv && q.size() > 0) begin
      chk(widx == q[0].blk, "R3/R6", "wr_idx", widx, q[0].blk);
      chk(wcnt == q[0].cnt, "R3/R7", "wr_count", wcnt, q[0].cnt);
      chk(wdata == q[0].d, "R3/R7", "wr_data_lo", wdata[63:0], q[0].d[63:0]);
    end
    mv = v; fl = f; mr = r;
    ma = 64'hC0DE_0000_0000_0000 + 64'(naddr) * 64'h40;
    #1;
    cnt = ptr % GROUP;
    busy = q.size() > 0;
    ofree = !busy || r;
    exp_rdy = !(f || pend) && !(cnt == GROUP - 1 && !ofree);
    chk(mrdy == exp_rdy, "R5/R9", "miss_ready", mrdy, exp_rdy);
    acc = v && exp_rdy;
    if (busy && r) void'(q.pop_front());
    exp_pv = acc;
    if (acc) begin
      exp_pi = ptr;
      st[cnt] = ma;
      naddr++;
      if (cnt == GROUP - 1) q.push_back('{ptr / GROUP, GROUP, pack(GROUP)});
      ptr = (ptr + 1) % DEPTH;
      if (ptr == 0) wraps++;
    end else if (f || pend) begin
      if (cnt == 0) pend = 0;
      else if (ofree) begin
        q.push_back('{ptr / GROUP, cnt, pack(cnt)});
        ptr = ((ptr / GROUP + 1) * GROUP) % DEPTH;
        if (ptr == 0) wraps++;
        pend = 0;
      end else pend = 1;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(mrdy == 1'b1, "R1", "reset ready", mrdy, 1);
    chk(wv == 1'b0, "R1", "reset wr_valid", wv, 0);
    chk(pv == 1'b0, "R1", "reset ptr_valid", pv, 0);
    rst_n = 1;
    // continuous stream, memory ready (R2, R3)
    for (int i = 0; i < 20; i++) step(1, 0, 1);
    // memory stalled while misses keep coming (R4, R5)
    for (int i = 0; i < 12; i++) step(1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 1);
    // sparse, irregular traffic
    for (int i = 0; i < 40; i++) step(i % 3 != 1, 0, i % 4 != 2);
    // partial flush (R7)
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    step(0, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    // empty flush (R8)
    step(0, 1, 1);
    step(1, 0, 1);
    // flush held off by backpressure, miss offered meanwhile (R7, R9)
    for (int i = 0; i < 6; i++) step(1, 0, 1);
    for (int i = 0; i < 2; i++) step(1, 0, 0);
    step(1, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 1);
    // long run over the log end (R6)
    for (int i = 0; i < 160; i++) step(1, 0, i % 7 != 3);
    step(0, 1, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 1);
    chk(wraps >= 2, "R6", "log wraps seen", wraps, 2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule